// File: doc/BRIEF.md
# Multi-channel match-compare timer

A register-mapped timer peripheral holding three independent up-counters. Each counter advances on a tick taken from one of four shared tick sources, picked by a per-timer select field. Each counter has three comparators. A comparator whose value equals the count at a counted tick sets its status bit. Software clears status bits by writing ones to them. Each timer drives one interrupt line, which is the OR of its status bits gated by their per-comparator enables.

A per-timer mode bit selects how the counter behaves on a match. In periodic mode, a match on comparator 0 returns the count to zero. In free-running mode the count runs on and wraps through zero. Reading a count goes through a capture register. A write to it takes a snapshot of the running count, and the readable value changes to that snapshot only after a fixed settling delay.

Each timer has a run state machine with two states. RUN_HALTED moves to RUN_COUNTING when the timer's enable bit is seen set, and the count is cleared on that transition. RUN_COUNTING moves back to RUN_HALTED when the bit is cleared, and the count holds its value. Each timer also has a capture state machine. CAP_IDLE moves to CAP_SETTLE on a capture write. CAP_SETTLE re-enters itself on a further capture write, which re-arms the delay with a fresh snapshot. CAP_SETTLE returns to CAP_IDLE once the delay has run out, publishing the snapshot as it does so.

Top module: `mct_timer`

## Requirements
- R1: After reset, every register reads zero except the match registers, which read all ones, and all interrupt lines are low. The register word addresses are: run enable at 0x00, clock select at 0x01, mode at 0x02, and timer t's block at 0x10+8t. Within a block, match k sits at +k, status at +3, interrupt enable at +4 and capture at +5.
- R2: Bit t of the run enable register (0x00) lets timer t count. A timer whose bit is clear holds its count through any ticks, and writing 0 halts all timers.
- R3: Setting a timer's enable bit while the timer is halted restarts its count from zero.
- R4: Timer t counts only on ticks of the tick source whose number is held in clock select bits [2t+1:2t] (register 0x01). Ticks on the other sources are ignored.
- R5: With the count starting at zero and comparator k loaded with N-1, status bit k (bit k of block offset +3) sets on the Nth counted tick and not before.
- R6: With mode bit t set (register 0x02, 1 = periodic), a tick that matches comparator 0 loads the count with zero, which gives a period of N ticks.
- R7: With mode bit t clear (free-running), the count keeps advancing past every match and wraps from all ones to zero.
- R8: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged, so writing 0x7 clears all three bits.
- R9: When a matching tick and a write of 1 to the same status bit fall in the same cycle, the bit stays set.
- R10: Interrupt line t is high exactly when some status bit of timer t is set together with the matching bit of its interrupt-enable register (block offset +4).
- R11: Writing a timer's capture register (block offset +5) snapshots its count. Reads return the previous capture value for four cycles after the write edge and the snapshot from the fourth edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_src_i | input | 4 | Tick enables of the four selectable count sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 3 | One interrupt line per timer |

## Verification
A counted tick updates the count and status at the same edge, and the interrupt line follows that status combinationally. An enable write takes effect one edge later, when the run state machine sees it. A capture becomes readable on the fourth edge after its write. The bench drives every input just after a rising edge and compares reads and interrupt lines at the next falling edge. It steps reads across the capture window one cycle at a time, so the old value is checked in each of the three cycles before the snapshot lands and the snapshot is checked in the cycle it first appears.

// File: rtl/mct_pkg.sv
package mct_pkg;
    localparam int REG_RUN  = 0;
    localparam int REG_CSEL = 1;
    localparam int REG_MODE = 2;
    localparam int OFS_W    = 3;
    localparam int CH_BLK0  = 2;
    localparam int OFS_STAT = 3;
    localparam int OFS_IE   = 4;
    localparam int OFS_CAP  = 5;

    typedef enum logic {
        RUN_HALTED,
        RUN_COUNTING
    } run_state_e;

    typedef enum logic {
        CAP_IDLE,
        CAP_SETTLE
    } cap_state_e;
endpackage

// File: rtl/mct_channel.sv
module mct_channel
    import mct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_CMP = 3
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            tick_i,
    input  logic                            run_en_i,
    input  logic                            periodic_i,
    input  logic [N_CMP-1:0][CNT_W-1:0]     match_i,
    input  logic [N_CMP-1:0]                clr_i,
    input  logic [N_CMP-1:0]                ie_i,
    output logic [CNT_W-1:0]                cnt_o,
    output logic [N_CMP-1:0]                status_o,
    output logic                            irq_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    run_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [N_CMP-1:0]   status_q, hit;
    logic               counting, restart;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RUN_HALTED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALTED:   if (run_en_i)  state_d = RUN_COUNTING;
            RUN_COUNTING: if (!run_en_i) state_d = RUN_HALTED;
            default:      state_d = RUN_HALTED;
        endcase
    end

    assign counting = (state_q == RUN_COUNTING) && run_en_i && tick_i;
    assign restart  = (state_q == RUN_HALTED) && run_en_i;

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        assign hit[k] = counting && (cnt_q == match_i[k]);

        AST_MATCH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) hit[k] |=> status_q[k]); // R9
        AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i[k] && !hit[k]) |=> !status_q[k]); // R8
    end

    always_comb begin
        cnt_d = cnt_q;
        if (restart)       cnt_d = '0;
        else if (counting) cnt_d = (periodic_i && hit[0]) ? '0 : cnt_q + CNT_ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q    <= '0;
            status_q <= '0;
        end else begin
            cnt_q    <= cnt_d;
            status_q <= (status_q & ~clr_i) | hit;
        end
    end

    always_comb begin
        irq_o    = |(status_q & ie_i);
        cnt_o    = cnt_q;
        status_o = status_q;
    end

    AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == RUN_HALTED && !run_en_i) |=> $stable(cnt_q)); // R2
    AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) restart |=> (cnt_q == '0)); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) (periodic_i && hit[0]) |=> (cnt_q == '0)); // R6
    AST_FREE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (counting && !(periodic_i && hit[0]) && (cnt_q == '1)) |=> (cnt_q == '0)); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (status_q == '0) |-> !irq_o); // R10
endmodule

// File: rtl/mct_capture.sv
module mct_capture
    import mct_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  cap_o
);
    localparam int               WAIT_W    = $clog2(SETTLE_CYC + 1);
    localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(SETTLE_CYC - 1);
    localparam logic [WAIT_W-1:0] WAIT_ONE  = WAIT_W'(1);

    cap_state_e         state_q, state_d;
    logic [WAIT_W-1:0]  wait_q;
    logic [CNT_W-1:0]   snap_q, vis_q;
    logic               publish;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CAP_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:   if (req_i) state_d = CAP_SETTLE;
            CAP_SETTLE: begin
                if (req_i)                state_d = CAP_SETTLE;
                else if (wait_q == '0)    state_d = CAP_IDLE;
            end
            default:    state_d = CAP_IDLE;
        endcase
    end

    assign publish = (state_q == CAP_SETTLE) && !req_i && (wait_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wait_q <= '0;
            snap_q <= '0;
            vis_q  <= '0;
        end else begin
            if (req_i) begin
                snap_q <= cnt_i;
                wait_q <= WAIT_INIT;
            end else if (state_q == CAP_SETTLE && wait_q != '0) begin
                wait_q <= wait_q - WAIT_ONE;
            end
            if (publish) vis_q <= snap_q;
        end
    end

    always_comb cap_o = vis_q;

    AST_CAP_PUBLISH: assert property (@(posedge clk_i) disable iff (!rst_ni) publish |=> (cap_o == $past(snap_q))); // R11
    AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !publish |=> $stable(cap_o)); // R11
    AST_SETTLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) wait_q <= WAIT_INIT); // R11
endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int N_TIMERS   = 3,
    parameter int N_CMP      = 3,
    parameter int CNT_W      = 32,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6,
    parameter int CSEL_W     = 2,
    parameter int SETTLE_CYC = 4,
    localparam int N_SRC     = 1 << CSEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SRC-1:0]  tick_src_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [N_TIMERS-1:0] irq_o
);
    localparam int BLK_W = ADDR_W - OFS_W;

    logic [N_TIMERS-1:0]                    run_q, mode_q, irq_w, tick_w, cap_req;
    logic [N_TIMERS*CSEL_W-1:0]             csel_q;
    logic [N_TIMERS-1:0][N_CMP-1:0][CNT_W-1:0] match_w;
    logic [N_TIMERS-1:0][N_CMP-1:0]         ie_w, status_w, clr_w;
    logic [N_TIMERS-1:0][CNT_W-1:0]         cnt_w, cap_w;
    logic [OFS_W-1:0]                       ofs;
    logic [BLK_W-1:0]                       blk;

    assign ofs = bus_addr_i[OFS_W-1:0];
    assign blk = bus_addr_i[ADDR_W-1:OFS_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q  <= '0;
            mode_q <= '0;
            csel_q <= '0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == ADDR_W'(REG_RUN))  run_q  <= bus_wdata_i[N_TIMERS-1:0];
            if (bus_addr_i == ADDR_W'(REG_MODE)) mode_q <= bus_wdata_i[N_TIMERS-1:0];
            if (bus_addr_i == ADDR_W'(REG_CSEL)) csel_q <= bus_wdata_i[N_TIMERS*CSEL_W-1:0];
        end
    end

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_ch
        localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(CH_BLK0 + t);

        logic                          ch_wr;
        logic [N_CMP-1:0][CNT_W-1:0]   match_r;
        logic [N_CMP-1:0]              ie_r;

        assign ch_wr = bus_wr_i && (blk == MY_BLK);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                match_r <= '1;
                ie_r    <= '0;
            end else if (ch_wr) begin
                for (int k = 0; k < N_CMP; k++) begin
                    if (ofs == OFS_W'(k)) match_r[k] <= bus_wdata_i[CNT_W-1:0];
                end
                if (ofs == OFS_W'(OFS_IE)) ie_r <= bus_wdata_i[N_CMP-1:0];
            end
        end

        assign match_w[t] = match_r;
        assign ie_w[t]    = ie_r;
        assign clr_w[t]   = (ch_wr && ofs == OFS_W'(OFS_STAT)) ? bus_wdata_i[N_CMP-1:0] : '0;
        assign cap_req[t] = ch_wr && (ofs == OFS_W'(OFS_CAP));
        assign tick_w[t]  = tick_src_i[csel_q[t*CSEL_W +: CSEL_W]];

        mct_channel #(
            .CNT_W (CNT_W),
            .N_CMP (N_CMP)
        ) u_ch (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .tick_i     (tick_w[t]),
            .run_en_i   (run_q[t]),
            .periodic_i (mode_q[t]),
            .match_i    (match_r),
            .clr_i      (clr_w[t]),
            .ie_i       (ie_r),
            .cnt_o      (cnt_w[t]),
            .status_o   (status_w[t]),
            .irq_o      (irq_w[t])
        );

        mct_capture #(
            .CNT_W      (CNT_W),
            .SETTLE_CYC (SETTLE_CYC)
        ) u_cap (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_i  (cap_req[t]),
            .cnt_i  (cnt_w[t]),
            .cap_o  (cap_w[t])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(REG_RUN))       bus_rdata_o[N_TIMERS-1:0] = run_q;
        else if (bus_addr_i == ADDR_W'(REG_CSEL)) bus_rdata_o[N_TIMERS*CSEL_W-1:0] = csel_q;
        else if (bus_addr_i == ADDR_W'(REG_MODE)) bus_rdata_o[N_TIMERS-1:0] = mode_q;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (blk == BLK_W'(CH_BLK0 + t)) begin
                for (int k = 0; k < N_CMP; k++) begin
                    if (ofs == OFS_W'(k)) bus_rdata_o[CNT_W-1:0] = match_w[t][k];
                end
                if (ofs == OFS_W'(OFS_STAT)) bus_rdata_o[N_CMP-1:0] = status_w[t];
                if (ofs == OFS_W'(OFS_IE))   bus_rdata_o[N_CMP-1:0] = ie_w[t];
                if (ofs == OFS_W'(OFS_CAP))  bus_rdata_o[CNT_W-1:0] = cap_w[t];
            end
        end
    end

    assign irq_o = irq_w;

    AST_CAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(cap_req)); // R11
endmodule

// File: tb/sim_mct_timer.sv
`timescale 1ns/1ps
module sim_mct_timer;
    localparam int CW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ts = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    always #4 clk = ~clk;

    mct_timer #(.CNT_W(CW)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_src_i  (ts),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Monitor: pops one expected item per falling edge and compares it.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t    it;
            logic [31:0] actual;
            it = sb_q.pop_front();
            actual = it.is_irq ? {29'b0, irq} : rdata;
            n_checks++;
            if (actual !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, actual, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1 wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1 wr = 1'b0;
    endtask

    task automatic write_with_tick(input logic [5:0] a, input logic [31:0] d, input int src);
        @(posedge clk); #1 wr = 1'b1; addr = a; wdata = d; ts[src] = 1'b1;
        @(posedge clk); #1 wr = 1'b0; ts[src] = 1'b0;
    endtask

    task automatic tick(input int src, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 ts[src] = 1'b1;
            @(posedge clk); #1 ts[src] = 1'b0;
        end
    endtask

    task automatic hold_tick(input int src, input int n);
        @(posedge clk); #1 ts[src] = 1'b1;
        repeat (n) @(posedge clk);
        #1 ts[src] = 1'b0;
    endtask

    task automatic expect_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1 addr = a;
        sb_q.push_back('{1'b0, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic [2:0] e, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{1'b1, {29'b0, e}, tag});
        @(negedge clk); #1;
    endtask

    task automatic capture_check(input logic [5:0] a, input logic [31:0] e, input string tag);
        bus_write(a, 32'h0);
        repeat (4) @(posedge clk);
        expect_reg(a, e, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_reg(6'h00, 32'h0,   "R1 run enable after reset");
        expect_reg(6'h01, 32'h0,   "R1 clock select after reset");
        expect_reg(6'h02, 32'h0,   "R1 mode after reset");
        expect_reg(6'h13, 32'h0,   "R1 status t0 after reset");
        expect_reg(6'h10, 32'h3FF, "R1 match0 t0 after reset");
        expect_reg(6'h1D, 32'h0,   "R1 capture t1 after reset");
        expect_irq(3'b000,         "R1 irq after reset");

        // Timer 0: periodic, match0 = 2 (period 3), irq enable on comparator 0
        bus_write(6'h02, 32'h1);
        bus_write(6'h10, 32'h2);
        bus_write(6'h14, 32'h1);
        bus_write(6'h00, 32'h1);
        tick(0, 2);
        expect_reg(6'h13, 32'h0, "R5 status t0 not yet set after 2 ticks");
        expect_irq(3'b000,       "R10 irq low with status clear");
        tick(0, 1);
        expect_reg(6'h13, 32'h1, "R5 status t0 set on 3rd tick");
        expect_irq(3'b001,       "R10 irq t0 with status and enable");
        tick(0, 2);
        // count: reload to 0 on tick 3, then 2 more -> 2
        bus_write(6'h15, 32'h0);
        expect_reg(6'h15, 32'h0, "R11 capture old value cycle 1");
        expect_reg(6'h15, 32'h0, "R11 capture old value cycle 2");
        expect_reg(6'h15, 32'h0, "R11 capture old value cycle 3");
        expect_reg(6'h15, 32'h2, "R6 periodic reload, R11 snapshot on 4th edge");

        // Status clearing
        bus_write(6'h13, 32'h0);
        expect_reg(6'h13, 32'h1, "R8 writing zero leaves status");
        bus_write(6'h13, 32'h1);
        expect_reg(6'h13, 32'h0, "R8 writing one clears status");
        expect_irq(3'b000,       "R10 irq drops with status");
        write_with_tick(6'h13, 32'h1, 0);
        expect_reg(6'h13, 32'h1, "R9 match wins over clear");
        write_with_tick(6'h13, 32'h1, 0);
        expect_reg(6'h13, 32'h0, "R8 clear with non-matching tick");

        // Timer 1: free-running, three comparators, irq on comparator 1 only
        bus_write(6'h01, 32'h24);
        bus_write(6'h18, 32'h2);
        bus_write(6'h19, 32'h4);
        bus_write(6'h1A, 32'h6);
        bus_write(6'h1C, 32'h2);
        bus_write(6'h00, 32'h3);
        tick(1, 3);
        expect_reg(6'h1B, 32'h1, "R5 t1 comparator 0 after 3 ticks");
        expect_irq(3'b000,       "R10 t1 irq masked for comparator 0");
        tick(1, 2);
        expect_reg(6'h1B, 32'h3, "R5 t1 comparator 1 after 5 ticks");
        expect_irq(3'b010,       "R10 t1 irq from comparator 1");
        tick(1, 2);
        expect_reg(6'h1B, 32'h7, "R5 t1 comparator 2 after 7 ticks");
        capture_check(6'h1D, 32'h7, "R7 free-running count passes matches");
        tick(2, 2);
        capture_check(6'h25, 32'h0, "R2 t2 idle while its enable bit clear");
        bus_write(6'h1B, 32'h7);
        expect_reg(6'h1B, 32'h0, "R8 writing 0x7 clears all");
        expect_irq(3'b000,       "R10 irq low after clear");

        // Clock select: timer 2 on source 2
        bus_write(6'h00, 32'h4);
        tick(0, 2);
        tick(1, 1);
        tick(2, 3);
        expect_reg(6'h01, 32'h24, "R4 clock select readback");
        capture_check(6'h25, 32'h3, "R4 t2 counts only its source");
        capture_check(6'h1D, 32'h7, "R2 t1 frozen when disabled");

        // Stop all, then restart
        bus_write(6'h00, 32'h0);
        tick(2, 2);
        expect_reg(6'h00, 32'h0, "R2 run enable cleared");
        capture_check(6'h25, 32'h3, "R2 t2 holds count when all stopped");
        bus_write(6'h00, 32'h4);
        tick(2, 1);
        capture_check(6'h25, 32'h1, "R3 restart from zero");

        // Wrap on timer 1 (10-bit counter in this bench)
        bus_write(6'h00, 32'h2);
        hold_tick(1, 1026);
        capture_check(6'h1D, 32'h2, "R7 count wraps through zero");
        expect_reg(6'h1B, 32'h7, "R7 matches seen across wrap");
        expect_reg(6'h02, 32'h1, "R6 mode readback");

        @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule